// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block is a direct-mapped table of `2^IDX_W` entries that is read with the fetch PC in the same cycle as the instruction cache, so the next fetch address is known before the instruction is decoded. Each slot keeps a valid flag, the full 32-bit PC of the control instruction as its tag, the predicted target and a 2-bit saturating direction counter. The lookup port is purely combinational. It returns the next fetch PC and a flag that tells whether a stored target was used.

Writes come only from the resolve port, which is driven when a branch or jump finishes in the execute stage. That port carries the instruction PC, a control-instruction flag, the actual direction and the actual target. In the same cycle the block compares the actual outcome with what the table currently predicts for that PC. A disagreement raises a kill output, which the pipeline uses to flush. The block only signals the kill and does not flush anything itself. The table is then trained. A taken transfer that misses is allocated. A hit has its counter stepped, and its target is replaced when it turns out wrong. Non-control instructions and not-taken misses leave the table alone.

Top module: `branch_target_buffer`

## Requirements
- R1: After a synchronous active-low reset every slot is invalid, so every lookup returns fetch PC + 4 with the taken flag low.
- R2: The slot index is PC bits [IDX_W+1:2]. Allocating a PC overwrites whatever entry held the same index, so the older PC then misses.
- R3: A hit requires a valid slot whose stored 32-bit PC equals the fetch PC exactly. A PC that shares the index but differs in other bits gets PC + 4 and taken low.
- R4: On a hit whose counter is 2 or 3 the next PC is the stored target and taken is high. On a hit whose counter is 0 or 1 the next PC is PC + 4 and taken is low.
- R5: A resolved taken control transfer that misses allocates its slot with its PC, its target and counter value 2 (weakly taken). A lookup of that PC in the following cycle predicts the target.
- R6: A resolved not-taken control instruction that misses allocates nothing.
- R7: An update with the control flag low never changes the table and never raises kill.
- R8: Kill is high, combinationally during a valid control update, exactly when the table's current prediction for that PC disagrees with the outcome. Disagreement means the direction differs, or both directions are taken but the targets differ. A miss counts as a not-taken prediction.
- R9: A correct prediction on a hit only steps the counter (taken: +1, not taken: -1). The stored target and tag stay unchanged.
- R10: A mispredicted hit stays valid. If the outcome was taken, the target is replaced by the actual target. The counter steps in the actual direction.
- R11: A write made by an update becomes visible to lookups from the next clock edge on. A lookup in the same cycle as the write sees the prior contents.
- R12: The counter saturates: +1 at 3 stays 3, and -1 at 0 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | 32 | PC being fetched this cycle |
| pred_next_pc | output | 32 | Predicted next fetch PC |
| pred_taken | output | 1 | High when the stored target was selected |
| upd_valid | input | 1 | A resolved instruction is presented this cycle |
| upd_pc | input | 32 | PC of the resolved instruction |
| upd_is_ctrl | input | 1 | Resolved instruction is a branch or jump |
| upd_taken | input | 1 | Actual direction |
| upd_target | input | 32 | Actual target address |
| upd_kill | output | 1 | Misprediction detected, flush younger work |

## Verification
Lookup and training can fall in the same cycle on the same slot. The bench provokes this by presenting a fetch of a PC while an allocating update for that same PC is applied. It expects the fetch in that cycle to still miss and return PC + 4, and it expects the stored target from the next cycle on. A second overlap is also covered: the kill decision reads the table in the same cycle as the slot is rewritten. This is judged by walking the counter through its whole range and checking kill against the state the table held before each update.

// File: rtl/btb_pkg.sv
// Shared types for the branch target buffer.
// Assumes a 2-bit direction counter whose upper bit is the taken guess.
package btb_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_t;

    // Saturating step of the direction counter toward the actual outcome.
    function automatic ctr_t ctr_step(ctr_t c, logic tk);
        ctr_t r;
        case (c)
            CTR_SNT: r = tk ? CTR_WNT : CTR_SNT;
            CTR_WNT: r = tk ? CTR_WT  : CTR_SNT;
            CTR_WT:  r = tk ? CTR_ST  : CTR_WNT;
            default: r = tk ? CTR_ST  : CTR_WT;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/btb_table.sv
// Entry storage: valid, full-PC tag, target and counter per slot.
// Two combinational read ports (fetch and resolve), one write port.
// Assumes at most one write per cycle; reset clears only the valid flags.
module btb_table
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_valid,
    output logic [PC_W-1:0]  lk_tag,
    output logic [PC_W-1:0]  lk_target,
    output ctr_t             lk_ctr,
    input  logic [IDX_W-1:0] rs_idx,
    output logic             rs_valid,
    output logic [PC_W-1:0]  rs_tag,
    output logic [PC_W-1:0]  rs_target,
    output ctr_t             rs_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PC_W-1:0]  wr_tag,
    input  logic [PC_W-1:0]  wr_target,
    input  ctr_t             wr_ctr
);
    localparam int ENTRIES = 1 << IDX_W;

    logic            valid_q  [ENTRIES];
    logic [PC_W-1:0] tag_q    [ENTRIES];
    logic [PC_W-1:0] target_q [ENTRIES];
    ctr_t            ctr_q    [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic hit_wr;
        assign hit_wr = wr_en && (wr_idx == IDX_W'(g));

        // Valid flag: cleared by reset, set on the first write to the slot.
        always_ff @(posedge clk) begin
            if (!rst_n)      valid_q[g] <= 1'b0;
            else if (hit_wr) valid_q[g] <= 1'b1;
        end

        // Payload fields: loaded whenever the slot is written.
        always_ff @(posedge clk) begin
            if (hit_wr) begin
                tag_q[g]    <= wr_tag;
                target_q[g] <= wr_target;
                ctr_q[g]    <= wr_ctr;
            end
        end
    end

    // Fetch-side read port.
    always_comb begin
        lk_valid  = valid_q[lk_idx];
        lk_tag    = tag_q[lk_idx];
        lk_target = target_q[lk_idx];
        lk_ctr    = ctr_q[lk_idx];
    end

    // Resolve-side read port.
    always_comb begin
        rs_valid  = valid_q[rs_idx];
        rs_tag    = tag_q[rs_idx];
        rs_target = target_q[rs_idx];
        rs_ctr    = ctr_q[rs_idx];
    end

    // R11: a write is present in the slot after the next edge.
    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)
                  && target_q[$past(wr_idx)] == $past(wr_target)
                  && ctr_q[$past(wr_idx)] == $past(wr_ctr));

    // R7 and R11: slots not written keep their payload.
    a_r11_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(lk_idx) -> ($stable(lk_tag) && $stable(lk_target) && $stable(lk_ctr)));

endmodule

// File: rtl/btb_match.sv
// Tag compare and next-PC selection for one read port.
// Assumes the entry fields belong to the slot indexed by pc.
module btb_match
    import btb_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pc,
    input  logic            ent_valid,
    input  logic [PC_W-1:0] ent_tag,
    input  logic [PC_W-1:0] ent_target,
    input  ctr_t            ent_ctr,
    output logic            hit,
    output logic            taken,
    output logic [PC_W-1:0] next_pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    // Full-PC compare and counter-based direction choice.
    always_comb begin
        hit     = ent_valid && (ent_tag == pc);
        taken   = hit && ent_ctr[1];
        next_pc = taken ? ent_target : pc + STEP;
    end

    // R4: a taken guess is only possible on a hit.
    a_r4_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> ent_valid && ent_tag == pc);

    // R3: a tag mismatch always falls through to the next word.
    a_r3_mismatch_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_tag != pc) |-> !taken);

endmodule

// File: rtl/btb_resolve.sv
// Resolve-side control: misprediction detection and training write.
// Assumes the entry inputs were read at the slot of upd_pc this cycle.
module btb_resolve
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic             upd_is_ctrl,
    input  logic             upd_taken,
    input  logic [PC_W-1:0]  upd_target,
    input  logic             hit,
    input  logic             pred_tk,
    input  logic [PC_W-1:0]  ent_target,
    input  ctr_t             ent_ctr,
    output logic             kill,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [PC_W-1:0]  wr_tag,
    output logic [PC_W-1:0]  wr_target,
    output ctr_t             wr_ctr
);
    logic active;
    logic wrong;

    // Compare the current guess with the actual outcome.
    always_comb begin
        active = upd_valid && upd_is_ctrl;
        wrong  = (pred_tk != upd_taken) || (pred_tk && upd_taken && ent_target != upd_target);
        kill   = active && wrong;
    end

    // Build the training write: allocate on taken miss, step counter on hit.
    always_comb begin
        wr_en     = active && (hit || upd_taken);
        wr_idx    = upd_pc[IDX_W+1:2];
        wr_tag    = upd_pc;
        wr_target = (upd_taken && (!hit || wrong)) ? upd_target : ent_target;
        wr_ctr    = hit ? ctr_step(ent_ctr, upd_taken) : CTR_WT;
    end

    // R7: non-control updates leave the table and kill alone.
    a_r7_nonctrl_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_is_ctrl) |-> !wr_en && !kill);

    // R6: a not-taken miss allocates nothing.
    a_r6_nt_miss_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_is_ctrl && !hit && !upd_taken) |-> !wr_en);

    // R8: a taken miss is always a misprediction.
    a_r8_taken_miss_kills: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_is_ctrl && !hit && upd_taken) |-> kill);

    // R9: a correct hit never changes the stored target.
    a_r9_keep_target: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit && !kill) |-> wr_target == ent_target);

endmodule

// File: rtl/branch_target_buffer.sv
// Top of the fetch-stage branch target buffer.
// Lookup is combinational on fetch_pc; training happens on the resolve port
// at the clock edge. Assumes word-aligned 32-bit PCs by default.
module branch_target_buffer
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic [PC_W-1:0] pred_next_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_is_ctrl,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    output logic            upd_kill
);
    logic             lk_valid, rs_valid;
    logic [PC_W-1:0]  lk_tag, lk_target, rs_tag, rs_target;
    ctr_t             lk_ctr, rs_ctr;
    logic             lk_hit, rs_hit, rs_tk;
    logic [PC_W-1:0]  rs_next;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [PC_W-1:0]  wr_tag, wr_target;
    ctr_t             wr_ctr;

    btb_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(fetch_pc[IDX_W+1:2]), .lk_valid(lk_valid), .lk_tag(lk_tag),
        .lk_target(lk_target), .lk_ctr(lk_ctr),
        .rs_idx(upd_pc[IDX_W+1:2]), .rs_valid(rs_valid), .rs_tag(rs_tag),
        .rs_target(rs_target), .rs_ctr(rs_ctr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
        .wr_target(wr_target), .wr_ctr(wr_ctr)
    );

    btb_match #(.PC_W(PC_W)) u_fetch_match (
        .clk(clk), .rst_n(rst_n), .pc(fetch_pc),
        .ent_valid(lk_valid), .ent_tag(lk_tag), .ent_target(lk_target), .ent_ctr(lk_ctr),
        .hit(lk_hit), .taken(pred_taken), .next_pc(pred_next_pc)
    );

    btb_match #(.PC_W(PC_W)) u_resolve_match (
        .clk(clk), .rst_n(rst_n), .pc(upd_pc),
        .ent_valid(rs_valid), .ent_tag(rs_tag), .ent_target(rs_target), .ent_ctr(rs_ctr),
        .hit(rs_hit), .taken(rs_tk), .next_pc(rs_next)
    );

    btb_resolve #(.PC_W(PC_W), .IDX_W(IDX_W)) u_resolve (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_is_ctrl(upd_is_ctrl),
        .upd_taken(upd_taken), .upd_target(upd_target),
        .hit(rs_hit), .pred_tk(rs_tk), .ent_target(rs_target), .ent_ctr(rs_ctr),
        .kill(upd_kill), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
        .wr_target(wr_target), .wr_ctr(wr_ctr)
    );

    // R5: a taken miss allocates a weakly-taken entry at its own slot.
    a_r5_alloc_weak: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_is_ctrl && upd_taken && !rs_hit)
            |-> wr_en && wr_ctr == CTR_WT && wr_tag == upd_pc && wr_target == upd_target);

    // R4: a hit with a taken guess redirects fetch off the sequential path.
    a_r4_hit_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_ctr[1]) |-> pred_taken && pred_next_pc == lk_target);

    // R8: the resolve-side guess and the kill agree on a correct taken hit.
    a_r8_no_kill_match: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_is_ctrl && rs_tk && upd_taken && rs_next == upd_target) |-> !upd_kill);

endmodule

// File: tb/tb_branch_target_buffer.sv
module tb_branch_target_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic [31:0] pred_next_pc;
    logic        pred_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_is_ctrl = 1'b0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        upd_kill;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    branch_target_buffer dut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_next_pc(pred_next_pc), .pred_taken(pred_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_is_ctrl(upd_is_ctrl),
        .upd_taken(upd_taken), .upd_target(upd_target), .upd_kill(upd_kill)
    );

    task automatic check_lookup(input logic [31:0] pc, input logic [31:0] exp_pc,
                                input logic exp_tk, input string req);
        @(negedge clk);
        fetch_pc = pc;
        #2;
        total++;
        if (pred_next_pc !== exp_pc || pred_taken !== exp_tk) begin
            bad++;
            $display("FAIL %s lookup %h: got next=%h tk=%b expected next=%h tk=%b",
                     req, pc, pred_next_pc, pred_taken, exp_pc, exp_tk);
        end
    endtask

    task automatic do_update(input logic [31:0] pc, input logic ctrl, input logic tk,
                             input logic [31:0] tgt, input logic exp_kill, input string req);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_is_ctrl = ctrl; upd_taken = tk; upd_target = tgt;
        #2;
        total++;
        if (upd_kill !== exp_kill) begin
            bad++;
            $display("FAIL %s update %h: got kill=%b expected kill=%b", req, pc, upd_kill, exp_kill);
        end
        @(posedge clk);
        #1 upd_valid = 1'b0;
    endtask

    // R1: empty table after reset.
    task automatic t_reset();
        check_lookup(32'h0000_0100, 32'h0000_0104, 1'b0, "R1");
        check_lookup(32'h0000_003C, 32'h0000_0040, 1'b0, "R1");
    endtask

    // R6: not-taken miss is predicted correctly and not allocated.
    task automatic t_nt_miss();
        do_update(32'h0000_0100, 1'b1, 1'b0, 32'h0000_0700, 1'b0, "R6");
        check_lookup(32'h0000_0100, 32'h0000_0104, 1'b0, "R6");
        do_update(32'h0000_0100, 1'b1, 1'b0, 32'h0000_0700, 1'b0, "R6");
    endtask

    // R5, R8, R4: taken miss allocates weakly taken and then hits.
    task automatic t_alloc();
        do_update(32'h0000_0100, 1'b1, 1'b1, 32'h0000_0400, 1'b1, "R8");
        check_lookup(32'h0000_0100, 32'h0000_0400, 1'b1, "R5");
        do_update(32'h0000_0100, 1'b1, 1'b1, 32'h0000_0400, 1'b0, "R8");
    endtask

    // R11: lookup and allocating write to the same slot in one cycle.
    task automatic t_same_cycle();
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = 32'h0000_0208; upd_is_ctrl = 1'b1;
        upd_taken = 1'b1; upd_target = 32'h0000_0800;
        fetch_pc = 32'h0000_0208;
        #2;
        total++;
        if (pred_next_pc !== 32'h0000_020C || pred_taken !== 1'b0) begin
            bad++;
            $display("FAIL R11 same-cycle lookup: got next=%h tk=%b expected next=%h tk=0",
                     pred_next_pc, pred_taken, 32'h0000_020C);
        end
        @(posedge clk);
        #1 upd_valid = 1'b0;
        #2;
        total++;
        if (pred_next_pc !== 32'h0000_0800 || pred_taken !== 1'b1) begin
            bad++;
            $display("FAIL R11 next-cycle lookup: got next=%h tk=%b expected next=%h tk=1",
                     pred_next_pc, pred_taken, 32'h0000_0800);
        end
    endtask

    // R3, R2: aliasing PC misses, then evicts the older entry.
    task automatic t_alias();
        check_lookup(32'h0000_1100, 32'h0000_1104, 1'b0, "R3");
        do_update(32'h0000_1100, 1'b1, 1'b1, 32'h0000_0900, 1'b1, "R2");
        check_lookup(32'h0000_0100, 32'h0000_0104, 1'b0, "R2");
        check_lookup(32'h0000_1100, 32'h0000_0900, 1'b1, "R2");
    endtask

    // R7: non-control updates are ignored.
    task automatic t_nonctrl();
        do_update(32'h0000_1100, 1'b0, 1'b1, 32'h0000_0050, 1'b0, "R7");
        check_lookup(32'h0000_1100, 32'h0000_0900, 1'b1, "R7");
        do_update(32'h0000_0310, 1'b0, 1'b1, 32'h0000_0060, 1'b0, "R7");
        check_lookup(32'h0000_0310, 32'h0000_0314, 1'b0, "R7");
    endtask

    // R12, R10, R9: walk the counter through its range.
    task automatic t_counter();
        do_update(32'h0000_3004, 1'b1, 1'b1, 32'h0000_0A00, 1'b1, "R5");   // -> 2
        do_update(32'h0000_3004, 1'b1, 1'b0, 32'h0000_3008, 1'b1, "R10");  // -> 1
        check_lookup(32'h0000_3004, 32'h0000_3008, 1'b0, "R10");
        do_update(32'h0000_3004, 1'b1, 1'b0, 32'h0000_3008, 1'b0, "R9");   // -> 0
        do_update(32'h0000_3004, 1'b1, 1'b0, 32'h0000_3008, 1'b0, "R12");  // stays 0
        do_update(32'h0000_3004, 1'b1, 1'b1, 32'h0000_0A00, 1'b1, "R12");  // -> 1
        check_lookup(32'h0000_3004, 32'h0000_3008, 1'b0, "R12");
        do_update(32'h0000_3004, 1'b1, 1'b1, 32'h0000_0A00, 1'b1, "R10");  // -> 2
        check_lookup(32'h0000_3004, 32'h0000_0A00, 1'b1, "R4");
        do_update(32'h0000_3004, 1'b1, 1'b1, 32'h0000_0A00, 1'b0, "R9");   // -> 3
        do_update(32'h0000_3004, 1'b1, 1'b1, 32'h0000_0A00, 1'b0, "R12");  // stays 3
        do_update(32'h0000_3004, 1'b1, 1'b0, 32'h0000_3008, 1'b1, "R12");  // -> 2
        check_lookup(32'h0000_3004, 32'h0000_0A00, 1'b1, "R12");
        do_update(32'h0000_3004, 1'b1, 1'b0, 32'h0000_3008, 1'b1, "R10");  // -> 1
        check_lookup(32'h0000_3004, 32'h0000_3008, 1'b0, "R4");
    endtask

    // R10, R8: wrong target on a taken hit replaces the target.
    task automatic t_target();
        do_update(32'h0000_4008, 1'b1, 1'b1, 32'h0000_0B00, 1'b1, "R5");   // -> 2
        do_update(32'h0000_4008, 1'b1, 1'b1, 32'h0000_0C00, 1'b1, "R8");   // -> 3, new tgt
        check_lookup(32'h0000_4008, 32'h0000_0C00, 1'b1, "R10");
        do_update(32'h0000_4008, 1'b1, 1'b0, 32'h0000_400C, 1'b1, "R10");  // -> 2
        check_lookup(32'h0000_4008, 32'h0000_0C00, 1'b1, "R9");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_nt_miss();
        t_alloc();
        t_same_cycle();
        t_alias();
        t_nonctrl();
        t_counter();
        t_target();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule